// File: doc/BRIEF.md
# Lockup-Free Full-Period Shift Sequencer

An 8-bit feedback shift register that walks through all 256 possible register values, the all-zeros value included, before it repeats. Its core is a maximal-length XOR feedback taken from stages 7, 5, 4 and 3. A nonlinear correction term, the NOR of the seven stages that stay in the register, is XORed into the incoming bit. That term inserts the all-zeros value between `8'h80` and `8'h01`, so the register cannot stick at zero. The period grows from 255 to 256.

The register advances one position per clock while the step enable is high. It holds its value otherwise. A parallel load forces any 8-bit seed into the register, zero included, and takes priority over stepping. A synchronous reset returns the register to `8'h01`. The full state is an output, and so is the serial bit that leaves the register on each step.

Top module: `fullperiod_seq`

## Requirements
- R1: A synchronous reset, sampled high at a rising clock edge, sets the state to 8'h01. Reset has priority over load and step.
- R2: When load is high and reset is low, the state after the edge equals the load value. Any 8-bit value is accepted, zero included. Load wins over step.
- R3: When reset, load and step are all low, the state does not change.
- R4: A step shifts the state one place toward the most significant bit: new bits [7:1] are the old bits [6:0]. The new bit 0 is old bit 7 XOR bit 5 XOR bit 4 XOR bit 3, further XORed with 1 when old bits [6:0] are all zero.
- R5: A step from the all-zeros state leads to 8'h01.
- R6: A step from 8'h80 leads to the all-zeros state.
- R7: From any seed, 256 consecutive steps visit 256 distinct states and return to the seed on the 256th step.
- R8: The serial output always equals state bit 7, which is the bit shifted out on the next step.
- R9: Over any 256 consecutive steps, the serial output is 1 on exactly 128 of them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| step_en | input | 1 | Advance the sequence by one step |
| load_en | input | 1 | Replace the state with load_val |
| load_val | input | 8 | Seed value for a load |
| state_q | output | 8 | Current register state |
| serial_bit | output | 1 | Bit shifted out on the next step (state bit 7) |

## Verification
Some behaviours hold across a single edge, and the bound checker tests them on every clock. These are the reset value, load priority, hold, the one-place shift, the two transitions around zero (8'h80 to zero, zero to 8'h01) and the serial tap. Other properties span a whole cycle of the sequence and only the bench's scenarios can show them. These are the full 256-step period with no repeated state, the return to the seed, and the balance of ones and zeros on the serial output. The bench runs these scenarios from several loaded seeds, including zero and 8'h80, and compares every clock against a behavioural model.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int unsigned SEQ_W    = 8;
    localparam int unsigned LOW_W    = SEQ_W - 1;

    typedef logic [SEQ_W-1:0] seq_word_t;

    // Stages 7, 5, 4 and 3 feed the linear part of the incoming bit.
    localparam seq_word_t TAP_MASK  = 8'b1011_1000;
    localparam seq_word_t RST_SEED  = 8'h01;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_STEP = 2'd1,
        OP_LOAD = 2'd2
    } seq_op_e;

    typedef struct packed {
        seq_op_e   op;
        seq_word_t data;
    } seq_cmd_t;

    function automatic logic low_all_zero(input seq_word_t s);
        return ~|s[LOW_W-1:0];
    endfunction

endpackage

// File: rtl/fcs_cmd_decode.sv
module fcs_cmd_decode
    import fcs_pkg::*;
(
    input  logic      step_en,
    input  logic      load_en,
    input  seq_word_t load_val,
    output seq_cmd_t  cmd
);
    always_comb begin
        cmd.data = load_val;
        if (load_en)
            cmd.op = OP_LOAD;
        else if (step_en)
            cmd.op = OP_STEP;
        else
            cmd.op = OP_HOLD;
    end
endmodule

// File: rtl/fcs_feedback.sv
module fcs_feedback
    import fcs_pkg::*;
#(
    parameter seq_word_t TAPS = TAP_MASK
) (
    input  seq_word_t cur,
    output seq_word_t nxt
);
    logic [SEQ_W-1:0] tapped;
    logic             lin_bit;
    logic             fill_bit;

    for (genvar i = 0; i < SEQ_W; i++) begin : g_tap
        if (TAPS[i]) begin : g_on
            assign tapped[i] = cur[i];
        end else begin : g_off
            assign tapped[i] = 1'b0;
        end
    end

    assign lin_bit  = ^tapped;
    assign fill_bit = lin_bit ^ low_all_zero(cur);
    assign nxt      = {cur[LOW_W-1:0], fill_bit};
endmodule

// File: rtl/fcs_state_reg.sv
module fcs_state_reg
    import fcs_pkg::*;
#(
    parameter seq_word_t SEED = RST_SEED
) (
    input  logic      clk,
    input  logic      rst,
    input  seq_cmd_t  cmd,
    input  seq_word_t stepped,
    output seq_word_t state
);
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= SEED;
        end else begin
            unique case (cmd.op)
                OP_LOAD: state <= cmd.data;
                OP_STEP: state <= stepped;
                default: state <= state;
            endcase
        end
    end
endmodule

// File: rtl/fullperiod_seq.sv
module fullperiod_seq
    import fcs_pkg::*;
#(
    parameter seq_word_t TAPS = TAP_MASK,
    parameter seq_word_t SEED = RST_SEED
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step_en,
    input  logic             load_en,
    input  logic [SEQ_W-1:0] load_val,
    output logic [SEQ_W-1:0] state_q,
    output logic             serial_bit
);
    seq_cmd_t  cmd;
    seq_word_t next_word;
    seq_word_t cur_word;

    fcs_cmd_decode u_dec (
        .step_en (step_en),
        .load_en (load_en),
        .load_val(load_val),
        .cmd     (cmd)
    );

    fcs_feedback #(.TAPS(TAPS)) u_fb (
        .cur(cur_word),
        .nxt(next_word)
    );

    fcs_state_reg #(.SEED(SEED)) u_reg (
        .clk    (clk),
        .rst    (rst),
        .cmd    (cmd),
        .stepped(next_word),
        .state  (cur_word)
    );

    assign state_q    = cur_word;
    assign serial_bit = cur_word[SEQ_W-1];
endmodule

// File: rtl/fcs_checker.sv
module fcs_checker
    import fcs_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             step_en,
    input logic             load_en,
    input logic [SEQ_W-1:0] load_val,
    input logic [SEQ_W-1:0] state_q,
    input logic             serial_bit
);
    p_reset_seed_r1: assert property (@(posedge clk)
        $past(rst) |-> state_q == RST_SEED);

    p_load_wins_r2: assert property (@(posedge clk) disable iff (rst)
        load_en |=> state_q == $past(load_val));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!load_en && !step_en) |=> $stable(state_q));

    p_shift_r4: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load_en) |=> state_q[SEQ_W-1:1] == $past(state_q[SEQ_W-2:0]));

    p_zero_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load_en && state_q == '0) |=> state_q == 8'h01);

    p_zero_entry_r6: assert property (@(posedge clk) disable iff (rst)
        (step_en && !load_en && state_q == 8'h80) |=> state_q == '0);

    p_serial_tap_r8: assert property (@(posedge clk) disable iff (rst)
        serial_bit == state_q[SEQ_W-1]);
endmodule

bind fullperiod_seq fcs_checker i_chk (
    .clk       (clk),
    .rst       (rst),
    .step_en   (step_en),
    .load_en   (load_en),
    .load_val  (load_val),
    .state_q   (state_q),
    .serial_bit(serial_bit)
);

// File: tb/test_fullperiod_seq.sv
`timescale 1ns/1ps
module test_fullperiod_seq;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       step_en = 1'b0;
    logic       load_en = 1'b0;
    logic [7:0] load_val = 8'h00;
    logic [7:0] state_q;
    logic       serial_bit;

    int checks = 0;
    int fails  = 0;
    int model  = 1;
    bit done   = 1'b0;

    fullperiod_seq i_fullperiod_seq (
        .clk       (clk),
        .rst       (rst),
        .step_en   (step_en),
        .load_en   (load_en),
        .load_val  (load_val),
        .state_q   (state_q),
        .serial_bit(serial_bit)
    );

    always #5 clk = ~clk;

    function automatic int ref_next(input int s);
        int b;
        b = ((s >> 7) & 1) ^ ((s >> 5) & 1) ^ ((s >> 4) & 1) ^ ((s >> 3) & 1);
        if ((s % 128) == 0) b = b ^ 1;
        return ((s * 2) % 256) + b;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input logic st, input logic ld, input int v);
        string tag;
        step_en  = st;
        load_en  = ld;
        load_val = v[7:0];
        @(posedge clk);
        if (rst)      begin model = 1;               tag = "R1"; end
        else if (ld)  begin model = v % 256;         tag = "R2"; end
        else if (st)  begin model = ref_next(model); tag = "R4"; end
        else          begin                          tag = "R3"; end
        @(negedge clk);
        check(state_q == model[7:0], tag, state_q, model);
        check(serial_bit == model[7], "R8", serial_bit, model[7]);
    endtask

    task automatic run_period(input int seed);
        bit [255:0] seen;
        int ones;
        seen = '0;
        ones = 0;
        tick(1'b0, 1'b1, seed);
        for (int k = 0; k < 256; k++) begin
            seen[state_q] = 1'b1;
            if (serial_bit) ones++;
            tick(1'b1, 1'b0, 0);
            if (k < 255)
                check(!seen[state_q], "R7 distinct", state_q, -1);
        end
        check(state_q == seed[7:0], "R7 return", state_q, seed);
        check(ones == 128, "R9 balance", ones, 128);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        rst = 1'b1;
        for (int i = 0; i < 3; i++) tick(1'b1, 1'b1, 8'hA5);
        rst = 1'b0;

        // R3: hold with no enables
        for (int i = 0; i < 3; i++) tick(1'b0, 1'b0, 8'h3C);

        // R4: free stepping from the reset seed
        for (int i = 0; i < 20; i++) tick(1'b1, 1'b0, 0);

        // R2: load beats step, zero accepted
        tick(1'b1, 1'b1, 8'h00);
        check(state_q == 8'h00, "R2 zero load", state_q, 0);
        // R5: leave zero immediately
        tick(1'b1, 1'b0, 0);
        check(state_q == 8'h01, "R5 zero exit", state_q, 1);

        // R6: 8'h80 enters zero
        tick(1'b0, 1'b1, 8'h80);
        tick(1'b1, 1'b0, 0);
        check(state_q == 8'h00, "R6 zero entry", state_q, 0);
        tick(1'b0, 1'b0, 0);
        check(state_q == 8'h00, "R3 hold at zero", state_q, 0);

        // R7 and R9 from several seeds
        run_period(8'h01);
        run_period(8'h00);
        run_period(8'h80);
        run_period(8'hA5);
        run_period(8'hFF);

        // R1: reset mid-run overrides load
        rst = 1'b1;
        tick(1'b1, 1'b1, 8'h77);
        rst = 1'b0;
        check(state_q == 8'h01, "R1 mid-run reset", state_q, 1);
        tick(1'b1, 1'b0, 0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule